// File: doc/BRIEF.md
# Streaming Sobel Edge Mask Generator

This block takes a raster stream of 24-bit RGB pixels, one per clock when `in_valid` is high, and attaches a one-bit edge flag to every pixel. Each pixel is reduced to an 8-bit gray level. Two line buffers and a three-column shift register then form a 3x3 gray neighbourhood. Horizontal and vertical Sobel gradients are computed in parallel, and their absolute values are added to estimate the edge strength. That strength is multiplied by a gain and compared against a threshold. The original pixel leaves the block unchanged, delayed to line up with its flag and its line and frame markers.

A small row tracker sets which pixels have a complete neighbourhood. It has four states: `NO_FRAME` (no frame start seen yet), `ROW_FIRST`, `ROW_SECOND` and `ROW_BODY`. Its transitions are:
- `frame_start`: any state goes to `ROW_FIRST` on a valid pixel with the frame marker.
- `line_step`: `ROW_FIRST` goes to `ROW_SECOND`, and `ROW_SECOND` goes to `ROW_BODY`, on a valid pixel with the line marker.
- `hold`: `ROW_BODY` and `NO_FRAME` stay where they are on a line marker.

The neighbourhood of a pixel is the 3x3 block whose lower-right corner is that pixel. It covers rows r-2..r and columns c-2..c of the current frame. The pipeline never stalls, so gaps in `in_valid` pass through it. The block sustains one pixel per clock.

Top module: `sobel_edge_mask`

## Requirements
- R1: Gray level is Y = (77·R + 150·G + 29·B) >> 8, with R = `in_rgb[23:16]`, G = `in_rgb[15:8]` and B = `in_rgb[7:0]`.
- R2: Over the neighbourhood, Gx = (right column weighted 1,2,1 top to bottom) − (left column weighted the same), and Gy = (bottom row weighted 1,2,1 left to right) − (top row weighted the same). The magnitude is |Gx| + |Gy|.
- R3: For a pixel with a complete neighbourhood, `out_mask` is 1 exactly when ((magnitude · `gain`) >> 4) ≥ `thresh`. Both control inputs are unsigned 8-bit values and must be held stable from 4 cycles before a frame's first pixel until 6 cycles after its last pixel.
- R4: Every valid input pixel reappears exactly 5 cycles later. `out_valid`, `out_rgb`, `out_sof` and `out_sol` are the input values, unchanged.
- R5: Pixels in the first two rows of a frame, or in the first two columns of a line (column index 0 or 1 after the line marker), get a mask of 0.
- R6: The neighbourhood is the 3x3 block ending at the pixel itself: rows r-2..r and columns c-2..c.
- R7: Cycles with `in_valid` low do not advance the column count, the line buffers or the window. `out_mask` is 0 whenever `out_valid` is 0.
- R8: A frame marker restarts the row count at once, even if the previous frame ended early.
- R9: During and right after reset, `out_valid` and `out_mask` are 0.
- R10: Pixels received before the first frame marker after reset get a mask of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel is present this cycle |
| in_sof | input | 1 | First pixel of a frame (also starts a line) |
| in_sol | input | 1 | First pixel of a line |
| in_rgb | input | 24 | Input pixel {R,G,B} |
| gain | input | 8 | Magnitude multiplier |
| thresh | input | 8 | Edge threshold |
| out_valid | output | 1 | Output pixel is present |
| out_sof | output | 1 | Delayed frame marker |
| out_sol | output | 1 | Delayed line marker |
| out_rgb | output | 24 | Delayed source pixel |
| out_mask | output | 1 | Edge flag for `out_rgb` |

## Verification
The bench builds the block with `LINE_W` = 8. This keeps frames of 8 by 3 to 6 pixels short enough for a few hundred cycles of stimulus. It still leaves six interior columns, so both border columns and full interior windows appear on every line. Gain values of 0, 16 and 255, together with thresholds of 0, 1 and 255, reach both ends of the comparison. Random gaps and a truncated frame exercise the idle-cycle and restart behaviour of the row tracker.

// File: rtl/sobel_pkg.sv
package sobel_pkg;
    localparam int PIPE_LAT = 5;

    typedef enum logic [1:0] {
        NO_FRAME   = 2'd0,
        ROW_FIRST  = 2'd1,
        ROW_SECOND = 2'd2,
        ROW_BODY   = 2'd3
    } row_state_t;

    // one column of the neighbourhood: [2]=top row, [1]=middle, [0]=bottom
    typedef logic [2:0][7:0] col3_t;
    // window: [0]=newest (rightmost) column, [2]=oldest (leftmost)
    typedef col3_t [2:0] win_t;

    typedef struct packed {
        logic        valid;
        logic        sof;
        logic        sol;
        logic        border;
        logic [23:0] rgb;
    } pix_tag_t;

    function automatic logic [9:0] tri_sum(input logic [7:0] a,
                                           input logic [7:0] mid,
                                           input logic [7:0] c);
        return {2'b00, a} + {1'b0, mid, 1'b0} + {2'b00, c};
    endfunction
endpackage

// File: rtl/edge_row_tracker.sv
module edge_row_tracker
    import sobel_pkg::*;
#(
    parameter int LINE_W = 640,
    localparam int COL_W = $clog2(LINE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             pix_sof,
    input  logic             pix_sol,
    output logic             border,
    output logic [COL_W-1:0] col
);
    row_state_t       state_q, state_d;
    logic [COL_W-1:0] col_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= NO_FRAME;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (pix_valid) begin
            if (pix_sof) begin
                state_d = ROW_FIRST;
            end else if (pix_sol) begin
                unique case (state_q)
                    NO_FRAME:   state_d = NO_FRAME;
                    ROW_FIRST:  state_d = ROW_SECOND;
                    ROW_SECOND: state_d = ROW_BODY;
                    ROW_BODY:   state_d = ROW_BODY;
                endcase
            end
        end
    end

    always_comb begin
        col    = (pix_sof || pix_sol) ? '0 : col_q;
        border = !((state_d == ROW_BODY) && (col >= COL_W'(2)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
        end else if (pix_valid) begin
            col_q <= (col == COL_W'(LINE_W)) ? col : col + COL_W'(1);
        end
    end
endmodule

// File: rtl/edge_line_window.sv
module edge_line_window
    import sobel_pkg::*;
#(
    parameter int LINE_W = 640,
    localparam int COL_W = $clog2(LINE_W + 1),
    localparam int ADR_W = (LINE_W > 1) ? $clog2(LINE_W) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic [COL_W-1:0] col,
    input  logic [7:0]       gray,
    output win_t             win
);
    logic [7:0]       line_near [LINE_W];
    logic [7:0]       line_far  [LINE_W];
    logic [ADR_W-1:0] addr;
    logic             in_range;
    logic [7:0]       rd_near, rd_far;

    always_comb begin
        in_range = col < COL_W'(LINE_W);
        addr     = in_range ? ADR_W'(col) : '0;
        rd_near  = line_near[addr];
        rd_far   = line_far[addr];
    end

    always_ff @(posedge clk) begin
        if (pix_valid && in_range) begin
            line_near[addr] <= gray;
            line_far[addr]  <= rd_near;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win <= '0;
        end else if (pix_valid) begin
            for (int k = 2; k > 0; k--) begin
                win[k] <= win[k-1];
            end
            win[0] <= {rd_far, rd_near, gray};
        end
    end
endmodule

// File: rtl/edge_gradient.sv
module edge_gradient
    import sobel_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  win_t        win,
    output logic [10:0] mag
);
    logic signed [10:0] gx_d, gy_d, gx_q, gy_q;
    logic [9:0]         abs_x, abs_y;
    logic [7:0]         unused_center;

    assign unused_center = win[1][1];

    always_comb begin
        gx_d = $signed({1'b0, tri_sum(win[0][2], win[0][1], win[0][0])})
             - $signed({1'b0, tri_sum(win[2][2], win[2][1], win[2][0])});
        gy_d = $signed({1'b0, tri_sum(win[2][0], win[1][0], win[0][0])})
             - $signed({1'b0, tri_sum(win[2][2], win[1][2], win[0][2])});
        abs_x = gx_q[10] ? 10'(-gx_q) : gx_q[9:0];
        abs_y = gy_q[10] ? 10'(-gy_q) : gy_q[9:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gx_q <= '0;
            gy_q <= '0;
            mag  <= '0;
        end else begin
            gx_q <= gx_d;
            gy_q <= gy_d;
            mag  <= {1'b0, abs_x} + {1'b0, abs_y};
        end
    end
endmodule

// File: rtl/sobel_edge_mask.sv
module sobel_edge_mask
    import sobel_pkg::*;
#(
    parameter int LINE_W = 640,
    localparam int COL_W = $clog2(LINE_W + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_sol,
    input  logic [23:0] in_rgb,
    input  logic [7:0]  gain,
    input  logic [7:0]  thresh,
    output logic        out_valid,
    output logic        out_sof,
    output logic        out_sol,
    output logic [23:0] out_rgb,
    output logic        out_mask
);
    logic             border_in;
    logic [COL_W-1:0] col_in, col_q;
    logic [15:0]      gray_sum;
    logic [7:0]       gray_q;
    pix_tag_t         tag_in;
    pix_tag_t         tag_q [PIPE_LAT];
    win_t             win;
    logic [10:0]      mag;
    logic [18:0]      scaled;
    logic             mask_q;

    edge_row_tracker #(.LINE_W(LINE_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .pix_valid(in_valid),
        .pix_sof(in_sof), .pix_sol(in_sol),
        .border(border_in), .col(col_in)
    );

    always_comb begin
        gray_sum = 16'd77  * {8'd0, in_rgb[23:16]}
                 + 16'd150 * {8'd0, in_rgb[15:8]}
                 + 16'd29  * {8'd0, in_rgb[7:0]};
        tag_in.valid  = in_valid;
        tag_in.sof    = in_valid & in_sof;
        tag_in.sol    = in_valid & (in_sol | in_sof);
        tag_in.border = border_in;
        tag_in.rgb    = in_rgb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gray_q <= '0;
            col_q  <= '0;
        end else begin
            gray_q <= gray_sum[15:8];
            col_q  <= col_in;
        end
    end

    // pixel tags ride alongside the datapath, one register per stage
    for (genvar s = 0; s < PIPE_LAT; s++) begin : g_tag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[s] <= '0;
            end else begin
                tag_q[s] <= (s == 0) ? tag_in : tag_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    edge_line_window #(.LINE_W(LINE_W)) u_window (
        .clk(clk), .rst_n(rst_n), .pix_valid(tag_q[0].valid),
        .col(col_q), .gray(gray_q), .win(win)
    );

    edge_gradient u_grad (
        .clk(clk), .rst_n(rst_n), .win(win), .mag(mag)
    );

    assign scaled = {8'd0, mag} * {11'd0, gain};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= 1'b0;
        end else begin
            mask_q <= tag_q[3].valid && (scaled >= {7'd0, thresh, 4'd0});
        end
    end

    always_comb begin
        out_valid = tag_q[PIPE_LAT-1].valid;
        out_sof   = tag_q[PIPE_LAT-1].sof;
        out_sol   = tag_q[PIPE_LAT-1].sol;
        out_rgb   = tag_q[PIPE_LAT-1].rgb;
        out_mask  = mask_q && !tag_q[PIPE_LAT-1].border;
    end
endmodule

// File: rtl/sobel_edge_mask_chk.sv
module sobel_edge_mask_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_sof,
    input logic [23:0] in_rgb,
    input logic        out_valid,
    input logic        out_sof,
    input logic        out_sol,
    input logic [23:0] out_rgb,
    input logic        out_mask
);
    logic [2:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 3'd7) begin
            age <= age + 3'd1;
        end
    end

    // R4
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5) |-> (out_valid == $past(in_valid, 5)));

    // R4
    pixel_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5 && out_valid) |-> (out_rgb == $past(in_rgb, 5)));

    // R4
    frame_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 3'd5) |-> (out_sof == $past(in_valid && in_sof, 5)));

    // R7
    mask_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_mask |-> out_valid);

    // R5
    line_start_border_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sol) |-> !out_mask);
endmodule

bind sobel_edge_mask sobel_edge_mask_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_rgb(in_rgb), .out_valid(out_valid), .out_sof(out_sof),
    .out_sol(out_sol), .out_rgb(out_rgb), .out_mask(out_mask)
);

// File: tb/tb_sobel_edge_mask.sv
`timescale 1ns/1ps
module tb_sobel_edge_mask;
    localparam int W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic [23:0] in_rgb = '0;
    logic [7:0]  gain = '0, thresh = '0;
    logic        out_valid, out_sof, out_sol, out_mask;
    logic [23:0] out_rgb;

    typedef struct packed {
        logic [23:0] rgb;
        logic        sof;
        logic        sol;
        logic        mask;
        logic        edge_px;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0, errors = 0;
    int   gref [0:7][0:7];
    bit   done = 1'b0;

    always #10 clk = ~clk;

    sobel_edge_mask #(.LINE_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_rgb(in_rgb), .gain(gain), .thresh(thresh),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_rgb(out_rgb), .out_mask(out_mask)
    );

    function automatic int gray_of(input logic [23:0] p);
        return (77 * int'(p[23:16]) + 150 * int'(p[15:8]) + 29 * int'(p[7:0])) >> 8;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // R1 R2 R3 R5 R6: reference mask for pixel (r,c), window ends at it
    function automatic logic ref_mask(input int r, input int c);
        int gx, gy, mag;
        if (r < 2 || c < 2) return 1'b0;
        gx = (gref[r-2][c] + 2*gref[r-1][c] + gref[r][c])
           - (gref[r-2][c-2] + 2*gref[r-1][c-2] + gref[r][c-2]);
        gy = (gref[r][c-2] + 2*gref[r][c-1] + gref[r][c])
           - (gref[r-2][c-2] + 2*gref[r-2][c-1] + gref[r-2][c]);
        mag = iabs(gx) + iabs(gy);
        return ((mag * int'(gain)) >> 4) >= int'(thresh);
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
        end
    endtask

    task automatic drive(input logic [23:0] p, input logic sof, input logic sol,
                         input logic m, input logic ep);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1; in_sof = sof; in_sol = sol; in_rgb = p;
        e.rgb = p; e.sof = sof; e.sol = sol; e.mask = m; e.edge_px = ep;
        exp_q.push_back(e);
    endtask

    task automatic send_frame(input int h, input int gap, input bit uniform);
        logic [23:0] base;
        logic [23:0] p;
        base = 24'($urandom);
        for (int r = 0; r < h; r++) begin
            for (int c = 0; c < W; c++) begin
                p = uniform ? base : 24'($urandom);
                gref[r][c] = gray_of(p);
                drive(p, (r == 0 && c == 0), (c == 0), ref_mask(r, c), (r >= 2 && c >= 2));
                if (gap > 0 && ($urandom % gap) == 0) idle(1 + int'($urandom % 3));
            end
        end
        idle(8);
    endtask

    task automatic set_ctrl(input logic [7:0] g, input logic [7:0] t);
        @(negedge clk);
        gain = g; thresh = t;
        idle(6);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                exp_t e;
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R4 unexpected output act=%h exp=none", out_rgb);
                end else begin
                    e = exp_q.pop_front();
                    if ({out_rgb, out_sof, out_sol} != {e.rgb, e.sof, e.sol}) begin
                        errors++;
                        $display("FAIL R4 pixel/markers act=%h/%b/%b exp=%h/%b/%b",
                                 out_rgb, out_sof, out_sol, e.rgb, e.sof, e.sol);
                    end
                    checks++;
                    if (out_mask !== e.mask) begin
                        errors++;
                        if (e.edge_px)
                            $display("FAIL R1 R2 R3 R6 mask act=%b exp=%b rgb=%h",
                                     out_mask, e.mask, e.rgb);
                        else
                            $display("FAIL R5 R8 R10 border mask act=%b exp=%b rgb=%h",
                                     out_mask, e.mask, e.rgb);
                    end
                end
            end else if (out_mask) begin
                checks++;
                errors++;
                $display("FAIL R7 mask without valid act=1 exp=0");
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_mask !== 1'b0) begin
            errors++;
            $display("FAIL R9 in reset act=%b%b exp=00", out_valid, out_mask);
        end
        rst_n = 1'b1;
        idle(3);
        checks++;
        if (out_valid !== 1'b0 || out_mask !== 1'b0) begin
            errors++;
            $display("FAIL R9 after reset act=%b%b exp=00", out_valid, out_mask);
        end

        // R10: gain 0 / thresh 0 would flag every interior pixel; none framed yet
        set_ctrl(8'd0, 8'd0);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < W; c++)
                drive(24'($urandom), 1'b0, (c == 0), 1'b0, 1'b0);
        idle(8);

        // R3 boundary (0 >= 0) and R5 borders on a flat frame
        send_frame(5, 0, 1'b1);
        // R2 R3 random content, no gaps
        set_ctrl(8'd16, 8'd40);
        send_frame(6, 0, 1'b0);
        // R7 gaps in valid, top gain and threshold
        set_ctrl(8'd255, 8'd255);
        send_frame(6, 3, 1'b0);
        // R8 truncated frame then a fresh one
        set_ctrl(8'd3, 8'd10);
        send_frame(3, 0, 1'b0);
        send_frame(5, 2, 1'b0);
        // R3 zero gain with nonzero threshold: never an edge
        set_ctrl(8'd0, 8'd1);
        send_frame(5, 0, 1'b0);
        // R2 flat image has zero gradient
        set_ctrl(8'd255, 8'd1);
        send_frame(5, 4, 1'b1);

        idle(4);
        done = 1'b1;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 pixels never emitted act=%0d exp=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule